// File: doc/BRIEF.md
# Drive Run and Protection Supervisor

This block sequences run and stop for a variable-frequency motor drive and turns the drive's protection comparators into latched trips. A start press enables running and releases the speed reference. A stop press only withdraws the reference, so the external ramp brings voltage and frequency down. Running ends once the ramp reports that the reference has reached a very low level. An average-overcurrent comparator raises a current-limit request that pulls the reference down without tripping.

Two trip types act on the gates in different ways. A peak overcurrent removes input-rectifier and commutation gating, drops run and forces every bridge switch on, which shorts the DC link through the bridge. A line undervoltage removes all input and bridge gating and drops run. Each trip starts a hold timer, so its action lasts for a minimum time even when the fault is momentary. A trip stays latched, with its cause shown on a two-bit status, until a new start press is accepted after the hold has run out.

Top module: `drive_supervisor`

## Requirements
- R1: During and directly after reset every output is 0: run, reference release, rectifier, bridge and commutation enables, bridge force-on, current-limit request, and a fault status of 0.
- R2: With no fault latched, a start press while stopped enables run, the reference release, and rectifier, bridge and commutation gating from the next cycle.
- R3: A stop press while running withdraws the reference release on the next cycle while run and all gating stay enabled. When start and stop arrive in the same cycle, stop wins.
- R4: While stopping, the ramp-low flag drops run and all gating on the next cycle. The flag has no effect while running with the reference released, nor while stopped.
- R5: The current-limit request is the average-overcurrent input delayed one cycle, gated by the run state that follows that cycle. It is 0 when not running and never changes the run state.
- R6: A peak overcurrent, in any state, gives on the next cycle: run 0, reference release 0, rectifier, bridge and commutation enables 0, bridge force-on 1, and fault status bit 0 set.
- R7: Bridge force-on stays 1 for exactly OC_HOLD_CYC cycles after the last cycle in which peak overcurrent was sampled high, even for a one-cycle fault.
- R8: A line undervoltage, in any state, gives on the next cycle: run, reference release and all gating 0, and fault status bit 1 set. Force-on stays 0 unless a peak overcurrent is also held.
- R9: A start press sampled while a trip hold is still active is ignored. That includes the last cycle in which the hold is visible: force-on still 1, or the UV_HOLD_CYC-th cycle after the last undervoltage sample. The first start after the hold is accepted and clears the fault status to 0.
- R10: After a trip and its hold, the drive stays off with the fault status kept until start is pressed.
- R11: Peak overcurrent and undervoltage in the same cycle set both fault bits (status 3). The overcurrent force-on applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start button, level sampled each cycle |
| stop_i | input | 1 | Stop button |
| ramp_low_i | input | 1 | Ramped reference is near zero |
| pk_oc_i | input | 1 | Peak overcurrent comparator |
| avg_oc_i | input | 1 | Average overcurrent comparator (about 150% of rating) |
| uv_i | input | 1 | Line undervoltage comparator (below about 80% of normal) |
| run_o | output | 1 | Drive is running or ramping down |
| ref_en_o | output | 1 | Speed reference released to the ramp |
| rect_gate_en_o | output | 1 | Input-rectifier gating allowed |
| bridge_gate_en_o | output | 1 | Bridge gating by the sequencer allowed |
| comm_en_o | output | 1 | Commutation gating allowed |
| bridge_force_on_o | output | 1 | Force all six bridge gates on |
| cur_lim_o | output | 1 | Current-limit request to the reference path |
| fault_o | output | 2 | Latched trip cause: bit 0 peak overcurrent, bit 1 undervoltage |

## Verification
Every output comes from state updated on the same edge that samples the inputs. A stimulus present at one edge is therefore seen on the outputs shortly after that edge, one cycle of latency for every result. A hold of N cycles stays visible on the N outputs following the last fault sample. The driver applies inputs on the falling edge and queues the outputs expected after the next rising edge. The monitor pops and compares them 2 ns after that rising edge. Hold boundaries are tested on the exact last blocked cycle and the first accepting cycle.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2,
    ST_TRIP = 2'd3
  } run_st_e;

  localparam int unsigned NUM_TRIPS = 2;
  localparam int unsigned TRIP_OC   = 0;
  localparam int unsigned TRIP_UV   = 1;
endpackage

// File: rtl/drv_trip_hold.sv
module drv_trip_hold #(
  parameter int unsigned HOLD_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;

  // retriggers while the fault persists
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (fault_i)       cnt_q <= CW'(HOLD_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/drv_run_fsm.sv
module drv_run_fsm
  import drv_sup_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    stop_i,
  input  logic    ramp_low_i,
  input  logic    trip_i,
  input  logic    hold_i,
  output run_st_e state_o,
  output run_st_e state_d_o,
  output logic    accept_o
);
  run_st_e state_q, state_d;
  logic    start_ok;

  assign start_ok = start_i && !stop_i && !hold_i;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    if (trip_i) begin
      state_d = ST_TRIP;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_TRIP: if (start_ok) begin
          state_d  = ST_RUN;
          accept_o = 1'b1;
        end
        ST_RUN: if (stop_i) state_d = ST_STOP;
        ST_STOP: begin
          if (start_ok)        state_d = ST_RUN;
          else if (ramp_low_i) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign state_d_o = state_d;
endmodule

// File: rtl/drv_gate_mask.sv
module drv_gate_mask
  import drv_sup_pkg::*;
(
  input  run_st_e state_i,
  input  logic    oc_hold_i,
  input  logic    uv_hold_i,
  output logic    run_o,
  output logic    ref_en_o,
  output logic    rect_gate_en_o,
  output logic    bridge_gate_en_o,
  output logic    comm_en_o,
  output logic    bridge_force_on_o
);
  logic running;

  assign running           = (state_i == ST_RUN) || (state_i == ST_STOP);
  assign run_o             = running;
  assign ref_en_o          = (state_i == ST_RUN);
  assign rect_gate_en_o    = running && !oc_hold_i && !uv_hold_i;
  assign bridge_gate_en_o  = running && !oc_hold_i && !uv_hold_i;
  assign comm_en_o         = running && !oc_hold_i;
  assign bridge_force_on_o = oc_hold_i;
endmodule

// File: rtl/drive_supervisor.sv
module drive_supervisor
  import drv_sup_pkg::*;
#(
  parameter int unsigned OC_HOLD_CYC = 64,
  parameter int unsigned UV_HOLD_CYC = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       ramp_low_i,
  input  logic       pk_oc_i,
  input  logic       avg_oc_i,
  input  logic       uv_i,
  output logic       run_o,
  output logic       ref_en_o,
  output logic       rect_gate_en_o,
  output logic       bridge_gate_en_o,
  output logic       comm_en_o,
  output logic       bridge_force_on_o,
  output logic       cur_lim_o,
  output logic [1:0] fault_o
);
  logic [NUM_TRIPS-1:0] trip_in, hold_act;
  logic                 trip_any, hold_any, accept;
  run_st_e              state_q, state_d;
  logic [NUM_TRIPS-1:0] fault_q;
  logic                 cur_lim_q;

  assign trip_in[TRIP_OC] = pk_oc_i;
  assign trip_in[TRIP_UV] = uv_i;
  assign trip_any         = |trip_in;
  assign hold_any         = |hold_act;

  drv_trip_hold #(.HOLD_CYC(OC_HOLD_CYC)) u_oc_hold (
    .clk_i, .rst_ni, .fault_i(trip_in[TRIP_OC]), .active_o(hold_act[TRIP_OC])
  );

  drv_trip_hold #(.HOLD_CYC(UV_HOLD_CYC)) u_uv_hold (
    .clk_i, .rst_ni, .fault_i(trip_in[TRIP_UV]), .active_o(hold_act[TRIP_UV])
  );

  drv_run_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i, .stop_i, .ramp_low_i,
    .trip_i(trip_any), .hold_i(hold_any),
    .state_o(state_q), .state_d_o(state_d), .accept_o(accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fault_q <= '0;
    else if (trip_any) fault_q <= fault_q | trip_in;
    else if (accept)   fault_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_lim_q <= 1'b0;
    else         cur_lim_q <= avg_oc_i && ((state_d == ST_RUN) || (state_d == ST_STOP));
  end

  drv_gate_mask u_mask (
    .state_i(state_q),
    .oc_hold_i(hold_act[TRIP_OC]),
    .uv_hold_i(hold_act[TRIP_UV]),
    .run_o, .ref_en_o, .rect_gate_en_o, .bridge_gate_en_o,
    .comm_en_o, .bridge_force_on_o
  );

  assign cur_lim_o = cur_lim_q;
  assign fault_o   = fault_q;
endmodule

// File: rtl/drive_supervisor_chk.sv
module drive_supervisor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       ramp_low_i,
  input logic       pk_oc_i,
  input logic       avg_oc_i,
  input logic       uv_i,
  input logic       run_o,
  input logic       ref_en_o,
  input logic       rect_gate_en_o,
  input logic       bridge_gate_en_o,
  input logic       comm_en_o,
  input logic       bridge_force_on_o,
  input logic       cur_lim_o,
  input logic [1:0] fault_o
);
  p_start_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && start_i && !stop_i && !pk_oc_i && !uv_i && fault_o == 2'b00 && !bridge_force_on_o)
    |=> (run_o && ref_en_o && rect_gate_en_o));

  p_stop_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_en_o && stop_i && !pk_oc_i && !uv_i) |=> (!ref_en_o && run_o));

  p_ramp_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_en_o && ramp_low_i && !stop_i && !pk_oc_i && !uv_i) |=> ref_en_o);

  p_curlim_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_lim_o |-> run_o);

  p_curlim_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avg_oc_i && ref_en_o && !stop_i && !pk_oc_i && !uv_i) |=> cur_lim_o);

  p_oc_action_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_oc_i |=> (!run_o && bridge_force_on_o && !rect_gate_en_o && !comm_en_o && fault_o[0]));

  p_hold_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bridge_force_on_o) |-> !$past(pk_oc_i));

  p_uv_action_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (!run_o && !rect_gate_en_o && !bridge_gate_en_o && fault_o[1]));

  p_hold_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bridge_force_on_o && start_i) |=> !run_o);

  p_both_trips_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pk_oc_i && uv_i) |=> (fault_o == 2'b11 && bridge_force_on_o));
endmodule

bind drive_supervisor drive_supervisor_chk u_chk (.*);

// File: tb/drive_supervisor_bench.sv
module drive_supervisor_bench;
  localparam int unsigned OC_H = 8;
  localparam int unsigned UV_H = 5;

  // input vector {start, stop, ramp, pk, avg, uv}
  localparam logic [5:0] I_NONE = 6'b000000, I_START = 6'b100000, I_STOP = 6'b010000,
                         I_RAMP = 6'b001000, I_PK = 6'b000100, I_AVG = 6'b000010,
                         I_UV = 6'b000001;
  // expected {run, ref, rect, bridge, comm, force, cl, fault[1:0]}
  localparam logic [8:0] E_IDLE = 9'b0_0_0_0_0_0_0_00, E_RUN = 9'b1_1_1_1_1_0_0_00,
                         E_STOP = 9'b1_0_1_1_1_0_0_00, E_CL  = 9'b0_0_0_0_0_0_1_00,
                         E_OCT  = 9'b0_0_0_0_0_1_0_01, E_OCD = 9'b0_0_0_0_0_0_0_01,
                         E_UVT  = 9'b0_0_0_0_0_0_0_10, E_BOTH = 9'b0_0_0_0_0_1_0_11;

  typedef struct {
    bit         chk;
    logic [8:0] exp;
    string      req;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, ramp_low_i = 0, pk_oc_i = 0, avg_oc_i = 0, uv_i = 0;
  logic run_o, ref_en_o, rect_gate_en_o, bridge_gate_en_o, comm_en_o, bridge_force_on_o, cur_lim_o;
  logic [1:0] fault_o;
  item_t q[$];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  drive_supervisor #(.OC_HOLD_CYC(OC_H), .UV_HOLD_CYC(UV_H)) u_drive_supervisor (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .ramp_low_i, .pk_oc_i, .avg_oc_i, .uv_i,
    .run_o, .ref_en_o, .rect_gate_en_o, .bridge_gate_en_o, .comm_en_o,
    .bridge_force_on_o, .cur_lim_o, .fault_o
  );

  function automatic logic [8:0] obs();
    return {run_o, ref_en_o, rect_gate_en_o, bridge_gate_en_o, comm_en_o,
            bridge_force_on_o, cur_lim_o, fault_o};
  endfunction

  task automatic compare(input logic [8:0] exp, input string req);
    n_chk++;
    if (obs() !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, obs(), exp, $time);
    end
  endtask

  task automatic step(input logic [5:0] iv, input bit chk, input logic [8:0] exp, input string req);
    item_t it;
    @(negedge clk);
    {start_i, stop_i, ramp_low_i, pk_oc_i, avg_oc_i, uv_i} = iv;
    it.chk = chk; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.chk) compare(it.exp, it.req);
    end
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(E_IDLE, "R1");
    rst_ni = 1'b1;
    step(I_NONE, 1, E_IDLE, "R1");
    step(I_START, 1, E_RUN, "R2");
    step(I_NONE, 1, E_RUN, "R2");
    step(I_AVG, 1, E_RUN | E_CL, "R5");
    step(I_NONE, 1, E_RUN, "R5");
    step(I_START | I_STOP, 1, E_STOP, "R3");
    step(I_NONE, 1, E_STOP, "R3");
    step(I_AVG, 1, E_STOP | E_CL, "R5");
    step(I_RAMP, 1, E_IDLE, "R4");
    step(I_AVG, 1, E_IDLE, "R5");
    step(I_RAMP, 1, E_IDLE, "R4");
    step(I_START, 1, E_RUN, "R2");
    step(I_RAMP, 1, E_RUN, "R4");
    // one-cycle peak overcurrent with a simultaneous start
    step(I_PK | I_START, 1, E_OCT, "R6");
    for (int i = 1; i < OC_H; i++) step((i == 3) ? I_START : I_NONE, 1, E_OCT, "R7");
    step(I_START, 1, E_OCD, "R9");
    step(I_NONE, 1, E_OCD, "R10");
    step(I_START, 1, E_RUN, "R9");
    // two-cycle undervoltage
    step(I_UV, 1, E_UVT, "R8");
    step(I_UV | I_START, 1, E_UVT, "R8");
    for (int i = 0; i < UV_H - 1; i++) step(I_NONE, 1, E_UVT, "R10");
    step(I_START, 1, E_UVT, "R9");
    step(I_START, 1, E_RUN, "R9");
    // both trips in one cycle
    step(I_PK | I_UV, 1, E_BOTH, "R11");
    step(I_NONE, 1, E_BOTH, "R11");
    step(I_NONE, 0, E_IDLE, "");
    while (q.size() > 0) @(posedge clk);
    #5;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule